// File: doc/BRIEF.md
# Shared Interrupt Affinity Routing Table

This block holds the routing state for a set of shared interrupts. Each interrupt owns an 8-byte route slot, reached through a 32-bit access port. Software writes an affinity word into the lower half of a slot. The block keeps that word exactly as written, so a later read returns it unchanged. In the same clock edge it compares the word against a parameter table of the affinities of the CPUs that are present.

The comparison yields either the index of the matching CPU or a reserved not-allocated marker. The block records that result for each interrupt. It also keeps, for every CPU, a bitmap of the shared interrupts routed to it. Delivery logic downstream consumes the per-CPU bitmaps and the per-interrupt CPU index. A one-cycle strobe tells it that a route has changed.

Top module: `spi_route_table`

## Requirements
- R1: After reset, every interrupt records CPU index 0 and reads back CPU 0's affinity word. In the target maps, CPU 0 has every interrupt bit set and every other CPU has none.
- R2: The interrupt selected by an access is the byte offset divided by 8, i.e. `req_addr[AW-1:3]`. A write with `req_addr[2]`=0 stores the full 32-bit word, and a later read of that slot returns it unchanged.
- R3: The upper half of a slot (`req_addr[2]`=1) reads as zero. Writes to it change no stored word, no CPU index and no target map, and do not pulse the update strobe.
- R4: A lower-half write whose full 32-bit word equals CPU c's table entry records index c in `route_cpu[8*s +: 8]` and sets bit `c*N_SPI+s` of `target_map`. It clears the bit of the previously recorded CPU and leaves every other interrupt's route untouched.
- R5: A lower-half write whose word matches no table entry records the marker 255 and leaves the interrupt's bit clear in every CPU's map. The word is still stored and read back.
- R6: A matching write to an interrupt that currently holds the marker replaces the marker with the new CPU index and sets that CPU's bit.
- R7: `route_update` is high for exactly the one cycle after each accepted lower-half write, and low otherwise.
- R8: A read request is answered one cycle later with `rsp_valid` high for one cycle and the data on `rsp_rdata`.
- R9: For every interrupt, at most one CPU's target map holds its bit. The bit is held exactly when the recorded index is below `N_CPU`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset into the route region |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| route_cpu | output | 8*N_SPI | Per-interrupt resolved CPU index, 255 = not allocated |
| target_map | output | N_CPU*N_SPI | Per-CPU interrupt bitmaps, bit c*N_SPI+s |
| route_update | output | 1 | One-cycle strobe after a route write |

## Verification
The bench moves one interrupt between CPUs and checks two things: a design that forgot to clear the old CPU's bit would leave the interrupt routed to two CPUs, and one that cleared the wrong bit would disturb other interrupts. It writes affinities that match no CPU, including one that differs only in the top byte. A design that dropped the word on a miss, or kept the stale target bit, would read back the wrong value or leave a bit set. It also hits the upper half of a slot with writes and reads: leaking those into the lower word or the strobe shows up as a changed read-back, a non-zero read or a spurious strobe.

// File: rtl/spi_route_table.sv
module spi_route_table #(
  parameter int N_SPI = 16,
  parameter int N_CPU = 4,
  parameter logic [N_CPU*32-1:0] CPU_AFF = {32'h0001_0000, 32'h0000_0100, 32'h0000_0001, 32'h0000_0000},
  localparam int IW = $clog2(N_SPI),
  localparam int AW = IW + 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [AW-1:0]          req_addr,
  input  logic [31:0]            req_wdata,
  output logic                   rsp_valid,
  output logic [31:0]            rsp_rdata,
  output logic [8*N_SPI-1:0]     route_cpu,
  output logic [N_CPU*N_SPI-1:0] target_map,
  output logic                   route_update
);
  localparam logic [7:0] NONE = 8'hFF;

  logic [31:0]      aff_q [N_SPI];
  logic [7:0]       cpu_q [N_SPI];
  logic [N_SPI-1:0] map_q [N_CPU];
  logic             upd_q, rv_q;
  logic [31:0]      rd_q;

  wire [IW-1:0] sel    = req_addr[AW-1:3];
  wire          hi     = req_addr[2];
  wire          in_rng = 32'(sel) < N_SPI;
  wire          wr_lo  = req_valid & req_write & ~hi & in_rng;

  logic       hit;
  logic [7:0] hit_idx;

  always_comb begin
    hit     = 1'b0;
    hit_idx = NONE;
    for (int c = N_CPU - 1; c >= 0; c--) begin
      if (req_wdata == CPU_AFF[c*32 +: 32]) begin
        hit     = 1'b1;
        hit_idx = 8'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < N_SPI; s++) begin
        aff_q[s] <= CPU_AFF[31:0];
        cpu_q[s] <= 8'd0;
      end
      for (int c = 0; c < N_CPU; c++) map_q[c] <= (c == 0) ? '1 : '0;
      upd_q <= 1'b0;
      rv_q  <= 1'b0;
      rd_q  <= '0;
    end else begin
      upd_q <= wr_lo;
      rv_q  <= req_valid & ~req_write;
      rd_q  <= (req_valid && !req_write && !hi && in_rng) ? aff_q[sel] : '0;
      if (wr_lo) begin
        aff_q[sel] <= req_wdata;
        cpu_q[sel] <= hit_idx;
        for (int c = 0; c < N_CPU; c++) begin
          if (cpu_q[sel] == 8'(c)) map_q[c][sel] <= 1'b0;
          if (hit && hit_idx == 8'(c)) map_q[c][sel] <= 1'b1;
        end
      end
    end
  end

  for (genvar s = 0; s < N_SPI; s++) begin : g_spi
    assign route_cpu[8*s +: 8] = cpu_q[s];
  end
  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    assign target_map[c*N_SPI +: N_SPI] = map_q[c];
  end

  assign route_update = upd_q;
  assign rsp_valid    = rv_q;
  assign rsp_rdata    = rd_q;
endmodule

// File: rtl/spi_route_table_chk.sv
module spi_route_table_chk #(
  parameter int N_SPI = 16,
  parameter int N_CPU = 4,
  localparam int AW = $clog2(N_SPI) + 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_write,
  input logic [AW-1:0]          req_addr,
  input logic                   rsp_valid,
  input logic [31:0]            rsp_rdata,
  input logic [8*N_SPI-1:0]     route_cpu,
  input logic [N_CPU*N_SPI-1:0] target_map,
  input logic                   route_update
);
  localparam logic [7:0] NC = 8'(N_CPU);

  for (genvar s = 0; s < N_SPI; s++) begin : g_col
    logic [N_CPU-1:0] col;
    for (genvar c = 0; c < N_CPU; c++) begin : g_bit
      assign col[c] = target_map[c*N_SPI + s];
    end

    a_r9_col_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));

    a_r5_marker_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (route_cpu[8*s +: 8] == 8'hFF) |-> (col == '0));

    a_r4_index_has_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (route_cpu[8*s +: 8] < NC) |-> ($countones(col) == 1));
  end

  a_r7_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    route_update |-> $past(req_valid && req_write && !req_addr[2]));

  a_r3_upper_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[2]) |=>
      (!route_update && $stable(route_cpu) && $stable(target_map)));

  a_r3_upper_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr[2]) |=> (rsp_rdata == 32'd0));

  a_r8_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
endmodule

bind spi_route_table spi_route_table_chk #(.N_SPI(N_SPI), .N_CPU(N_CPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .route_cpu(route_cpu), .target_map(target_map), .route_update(route_update)
);

// File: tb/spi_route_table_bench.sv
`timescale 1ns/1ps
module spi_route_table_bench;
  localparam int N_SPI = 16;
  localparam int N_CPU = 4;
  localparam int AW    = 7;
  localparam logic [31:0] AFF [N_CPU] = '{32'h0000_0000, 32'h0000_0001, 32'h0000_0100, 32'h0001_0000};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, route_update;
  logic [31:0] rsp_rdata;
  logic [8*N_SPI-1:0] route_cpu;
  logic [N_CPU*N_SPI-1:0] target_map;

  always #2.5 clk = ~clk;

  spi_route_table u_spi_route_table (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .route_cpu(route_cpu), .target_map(target_map),
    .route_update(route_update)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_aff [N_SPI];
  logic [7:0]  exp_cpu [N_SPI];
  logic [31:0] rq [$];
  string       rtag [$];

  function automatic logic [7:0] resolve(logic [31:0] v);
    for (int c = 0; c < N_CPU; c++) if (AFF[c] == v) return 8'(c);
    return 8'hFF;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_state(string tag);
    logic [N_CPU*N_SPI-1:0] em;
    logic [8*N_SPI-1:0] ec;
    em = '0;
    for (int s = 0; s < N_SPI; s++) begin
      ec[8*s +: 8] = exp_cpu[s];
      if (exp_cpu[s] < N_CPU) em[32'(exp_cpu[s])*N_SPI + s] = 1'b1;
    end
    chk({tag, " route_cpu"}, 64'(route_cpu[63:0]), 64'(ec[63:0]));
    chk({tag, " route_cpu hi"}, 64'(route_cpu[127:64]), 64'(ec[127:64]));
    chk({tag, " target_map"}, 64'(target_map), 64'(em));
  endtask

  task automatic wr(int s, bit hi, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = AW'(s*8 + (hi ? 4 : 0)); req_wdata = d;
    if (!hi) begin exp_aff[s] = d; exp_cpu[s] = resolve(d); end
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(int s, bit hi, string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = AW'(s*8 + (hi ? 4 : 0));
    rq.push_back(hi ? 32'd0 : exp_aff[s]);
    rtag.push_back(tag);
    @(negedge clk);
    req_valid = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (rq.size() == 0) chk("R8 unexpected response", 64'(rsp_rdata), 64'hx);
      else chk(rtag.pop_front(), 64'(rsp_rdata), 64'(rq.pop_front()));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int s = 0; s < N_SPI; s++) begin exp_aff[s] = AFF[0]; exp_cpu[s] = 8'd0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_state("R1 reset");
    chk("R1 reset strobe", 64'(route_update), 64'd0);
    rd(0, 0, "R1 reset readback spi0");
    rd(15, 0, "R1 reset readback spi15");

    wr(3, 0, AFF[2]);
    chk("R7 strobe after write", 64'(route_update), 64'd1);
    chk_state("R4 move spi3 to cpu2");
    @(negedge clk);
    chk("R7 strobe one cycle", 64'(route_update), 64'd0);
    rd(3, 0, "R2 readback spi3");

    wr(3, 1, 32'hFFFF_FFFF);
    chk("R3 no strobe on upper write", 64'(route_update), 64'd0);
    chk_state("R3 upper write ignored");
    rd(3, 1, "R3 upper reads zero");
    rd(3, 0, "R3 lower word untouched");

    wr(3, 0, 32'h00AB_CDEF);
    chk_state("R5 unmatched spi3");
    rd(3, 0, "R5 unmatched readback");
    wr(4, 0, 32'h0100_0001);
    chk_state("R5 top byte differs");
    rd(4, 0, "R5 top byte readback");

    wr(3, 0, AFF[3]);
    chk_state("R6 marker replaced");
    wr(4, 0, AFF[1]);
    chk_state("R6 spi4 to cpu1");

    for (int s = 0; s < N_SPI; s++) begin
      wr(s, 0, (s % 5 == 4) ? 32'h0000_0200 + 32'(s) : AFF[s % N_CPU]);
      chk_state("R4 sweep");
    end
    for (int s = 0; s < N_SPI; s++) rd(s, 0, "R2 sweep readback");

    wr(9, 0, AFF[0]);
    wr(9, 0, AFF[0]);
    chk_state("R9 repeated same route");
    rd(9, 0, "R2 repeated readback");

    repeat (3) @(negedge clk);
    chk("R8 all reads answered", 64'(rq.size()), 64'd0);
    finish_run();
  end
endmodule